// File: doc/BRIEF.md
# UART Register Bank

This block is the software-visible face of a UART. A simple register bus reaches sixteen 32-bit word slots. Seven of them are in use: line control, mode control, status, error status, transmit holding buffer, receive holding buffer and baud divisor. The remaining slots return zero. The line-control fields, the break and loopback controls and the baud divisor are driven straight out to the serial engines.

In the other direction, the transmitter tells the bank when it has taken the holding byte and when its shifter is idle. The receiver pushes each received byte together with its parity, framing and break indications. From these flags the bank keeps ready, empty, complete and sticky error bits. A two-bit mode field per direction then sends the pending condition to one request path: the interrupt line or one of two DMA request lines. A separate enable also raises the interrupt while any error bit is set.

Reads return data one cycle after the request, on a registered output. Reading a slot can have side effects: reading the receive buffer consumes the byte, and reading the error register clears it.

Top module: `uart_regbank`

## Requirements
- R1: After reset, slots 0, 1, 5, 8, 9 and 10 read zero, the status slot 4 reads 0x6 (transmit empty and transmit complete set), and irq and every DMA request line are low.
- R2: Line control (slot 0) keeps bits [6:0]: [1:0] word length, [2] two stop bits, [5:3] parity mode, [6] infrared. Mode control (slot 1) keeps bits [6:0]: [1:0] receive mode, [3:2] transmit mode, [4] send break, [5] loopback, [6] receive-status interrupt enable. The baud divisor (slot 10) keeps DIV_W bits. Each reads back what was written, with unused upper bits reading zero, and drives the matching output ports.
- R3: A receive push stores the byte and sets status bit 0. Reading slot 9 returns that byte and clears bit 0, unless a push arrives in the same cycle.
- R4: Writing slot 8 stores the byte on tx_data and clears status bit 1 (empty) and bit 2 (complete). tx_taken sets bit 1 again. Bit 2 sets once tx_shift_idle is high while bit 1 is set.
- R5: Error status (slot 5) bits are sticky: bit 0 overrun (a push while data is still unread), bit 1 parity, bit 2 framing, bit 3 break. Reading slot 5 returns them and clears them, and an error arriving in that same cycle wins over the clear.
- R6: The receive mode selects the receive request path: 0 gives no request, 1 raises irq, 2 raises rx_dma_req[0] and 3 raises rx_dma_req[1]. The request is held while status bit 0 is set.
- R7: The transmit mode uses the same encoding on irq and tx_dma_req[1:0], and the request is held while status bit 1 is set.
- R8: With mode bit 6 set, irq is high while any error status bit is set.
- R9: Unmapped slots read zero and ignore writes. Writes to slots 4, 5 and 9 change nothing.
- R10: bus_rvalid is high, and bus_rdata holds the slot contents, in the cycle after a read request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_index | input | 4 | Word slot index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| line_word_len | output | 2 | Word length code |
| line_two_stop | output | 1 | Two stop bits |
| line_parity | output | 3 | Parity mode code |
| line_infrared | output | 1 | Infrared signalling mode |
| send_break | output | 1 | Hold the transmit line in break |
| loopback | output | 1 | Route transmit back into receive |
| baud_div | output | DIV_W (32) | Baud divisor |
| tx_data | output | 8 | Transmit holding byte |
| tx_pending | output | 1 | Holding byte waits for the transmitter |
| tx_taken | input | 1 | Transmitter took the holding byte |
| tx_shift_idle | input | 1 | Transmit shifter idle |
| rx_push | input | 1 | Receiver delivers a byte |
| rx_byte | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error seen |
| rx_frame_err | input | 1 | Framing error seen |
| rx_break | input | 1 | Break seen |
| irq | output | 1 | Interrupt request |
| rx_dma_req | output | 2 | Receive DMA requests, channel 0 and 1 |
| tx_dma_req | output | 2 | Transmit DMA requests, channel 0 and 1 |

## Verification
A wrong flag or error bit shows up on irq or a DMA line in the very next cycle, because the request outputs are combinational from the stored flags. The same fault also appears in the next read of slot 4 or slot 5. A consumed byte whose ready bit is not cleared keeps the request asserted after the read of slot 9. It also marks the next push as an overrun. A wrong slot decode shows up as nonzero data from an unmapped slot, or as a control value that changes after a write that should have had no effect. All of these appear on bus_rdata one cycle after the offending read.

// File: rtl/urb_pkg.sv
package urb_pkg;
  localparam int unsigned SLOT_W = 4;
  localparam int unsigned NSLOT  = 1 << SLOT_W;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned CFG_W  = 7;
  localparam int unsigned NCH    = 2;

  localparam logic [SLOT_W-1:0] IDX_LINE = 4'd0;
  localparam logic [SLOT_W-1:0] IDX_MODE = 4'd1;
  localparam logic [SLOT_W-1:0] IDX_STAT = 4'd4;
  localparam logic [SLOT_W-1:0] IDX_ERR  = 4'd5;
  localparam logic [SLOT_W-1:0] IDX_TXB  = 4'd8;
  localparam logic [SLOT_W-1:0] IDX_RXB  = 4'd9;
  localparam logic [SLOT_W-1:0] IDX_BAUD = 4'd10;

  typedef enum logic [1:0] {
    REQ_OFF = 2'd0,
    REQ_IRQ = 2'd1,
    REQ_CH0 = 2'd2,
    REQ_CH1 = 2'd3
  } req_mode_e;

  typedef struct packed {
    logic       infrared;
    logic [2:0] parity;
    logic       two_stop;
    logic [1:0] word_len;
  } line_cfg_t;

  typedef struct packed {
    logic      stat_ie;
    logic      loopback;
    logic      send_break;
    req_mode_e tx_mode;
    req_mode_e rx_mode;
  } mode_cfg_t;

  function automatic logic slot_mapped(input logic [SLOT_W-1:0] idx);
    return (idx == IDX_LINE) || (idx == IDX_MODE) || (idx == IDX_STAT) ||
           (idx == IDX_ERR)  || (idx == IDX_TXB)  || (idx == IDX_RXB)  ||
           (idx == IDX_BAUD);
  endfunction
endpackage

// File: rtl/urb_decode.sv
module urb_decode
  import urb_pkg::*;
#(
  parameter int unsigned N = NSLOT
) (
  input  logic              valid,
  input  logic              write,
  input  logic [SLOT_W-1:0] index,
  output logic [N-1:0]      wr_sel,
  output logic [N-1:0]      rd_sel
);
  for (genvar s = 0; s < N; s++) begin : g_slot
    localparam logic [SLOT_W-1:0] SLOT = SLOT_W'(s);
    logic hit;
    assign hit       = valid && (index == SLOT);
    assign wr_sel[s] = hit && write;
    assign rd_sel[s] = hit && !write;
  end
endmodule

// File: rtl/urb_cfg.sv
module urb_cfg
  import urb_pkg::*;
#(
  parameter int unsigned DIV_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_line,
  input  logic             wr_mode,
  input  logic             wr_baud,
  input  logic [CFG_W-1:0] wdata_cfg,
  input  logic [DIV_W-1:0] wdata_div,
  output line_cfg_t        line_q,
  output mode_cfg_t        mode_q,
  output logic [DIV_W-1:0] baud_q
);
  line_cfg_t        line_d;
  mode_cfg_t        mode_d;
  logic [DIV_W-1:0] baud_d;

  always_comb begin
    line_d = line_q;
    mode_d = mode_q;
    baud_d = baud_q;
    if (wr_line) line_d = line_cfg_t'(wdata_cfg);
    if (wr_mode) mode_d = mode_cfg_t'(wdata_cfg);
    if (wr_baud) baud_d = wdata_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      mode_q <= '0;
      baud_q <= '0;
    end else begin
      if (wr_line) line_q <= line_d;
      if (wr_mode) mode_q <= mode_d;
      if (wr_baud) baud_q <= baud_d;
    end
  end

  AST_MODE_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_q == mode_cfg_t'($past(wdata_cfg)))); // R2
endmodule

// File: rtl/urb_flags.sv
module urb_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_txb,
  input  logic              rd_rxb,
  input  logic              rd_err,
  input  logic [DATA_W-1:0] wdata_byte,
  input  logic              tx_taken,
  input  logic              tx_shift_idle,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  output logic              rx_ready_q,
  output logic              tx_empty_q,
  output logic              tx_done_q,
  output logic [3:0]        err_q,
  output logic [DATA_W-1:0] rx_buf_q,
  output logic [DATA_W-1:0] tx_buf_q
);
  logic       rx_ready_d, tx_empty_d, tx_done_d;
  logic [3:0] err_d;
  logic       overrun_hit;
  logic       err_en;

  assign overrun_hit = rx_push && rx_ready_q && !rd_rxb;
  assign err_en      = rd_err || overrun_hit || rx_parity_err || rx_frame_err || rx_break;

  always_comb begin
    rx_ready_d = rx_ready_q;
    if (rd_rxb)  rx_ready_d = 1'b0;
    if (rx_push) rx_ready_d = 1'b1;

    err_d = rd_err ? 4'b0000 : err_q;
    err_d = err_d | {rx_break, rx_frame_err, rx_parity_err, overrun_hit};

    tx_empty_d = tx_empty_q;
    tx_done_d  = tx_done_q;
    if (wr_txb) begin
      tx_empty_d = 1'b0;
      tx_done_d  = 1'b0;
    end else begin
      if (tx_taken)                  tx_empty_d = 1'b1;
      if (tx_shift_idle && tx_empty_q) tx_done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ready_q <= 1'b0;
      tx_empty_q <= 1'b1;
      tx_done_q  <= 1'b1;
      err_q      <= '0;
      rx_buf_q   <= '0;
      tx_buf_q   <= '0;
    end else begin
      rx_ready_q <= rx_ready_d;
      tx_empty_q <= tx_empty_d;
      tx_done_q  <= tx_done_d;
      if (err_en)  err_q    <= err_d;
      if (rx_push) rx_buf_q <= rx_byte;
      if (wr_txb)  tx_buf_q <= wdata_byte;
    end
  end

  AST_RXB_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxb && !rx_push) |=> !rx_ready_q); // R3
  AST_TXB_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_txb |=> (!tx_empty_q && !tx_done_q)); // R4
  AST_OVERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_ready_q && !rd_rxb) |=> err_q[0]); // R5
  AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !rx_push && !rx_parity_err && !rx_frame_err && !rx_break) |=> (err_q == 4'b0000)); // R5
endmodule

// File: rtl/urb_req.sv
module urb_req
  import urb_pkg::*;
(
  input  req_mode_e      rx_mode,
  input  req_mode_e      tx_mode,
  input  logic           stat_ie,
  input  logic           rx_ready,
  input  logic           tx_empty,
  input  logic           err_any,
  output logic           irq,
  output logic [NCH-1:0] rx_dma,
  output logic [NCH-1:0] tx_dma
);
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    localparam logic [1:0] CODE = 2'(int'(REQ_CH0) + c);
    assign rx_dma[c] = rx_ready && (rx_mode == req_mode_e'(CODE));
    assign tx_dma[c] = tx_empty && (tx_mode == req_mode_e'(CODE));
  end

  assign irq = (rx_ready && (rx_mode == REQ_IRQ)) ||
               (tx_empty && (tx_mode == REQ_IRQ)) ||
               (stat_ie && err_any);
endmodule

// File: rtl/uart_regbank.sv
module uart_regbank
  import urb_pkg::*;
#(
  parameter int unsigned DIV_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [3:0]        bus_index,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              bus_rvalid,
  output logic [1:0]        line_word_len,
  output logic              line_two_stop,
  output logic [2:0]        line_parity,
  output logic              line_infrared,
  output logic              send_break,
  output logic              loopback,
  output logic [DIV_W-1:0]  baud_div,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_pending,
  input  logic              tx_taken,
  input  logic              tx_shift_idle,
  input  logic              rx_push,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              rx_parity_err,
  input  logic              rx_frame_err,
  input  logic              rx_break,
  output logic              irq,
  output logic [1:0]        rx_dma_req,
  output logic [1:0]        tx_dma_req
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NSLOT-1:0] wr_sel, rd_sel;

  urb_decode #(.N(NSLOT)) u_decode (
    .valid (bus_valid),
    .write (bus_write),
    .index (bus_index),
    .wr_sel(wr_sel),
    .rd_sel(rd_sel)
  );

  line_cfg_t        line_q;
  mode_cfg_t        mode_q;
  logic [DIV_W-1:0] baud_q;

  urb_cfg #(.DIV_W(DIV_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_line  (wr_sel[IDX_LINE]),
    .wr_mode  (wr_sel[IDX_MODE]),
    .wr_baud  (wr_sel[IDX_BAUD]),
    .wdata_cfg(bus_wdata[CFG_W-1:0]),
    .wdata_div(bus_wdata[DIV_W-1:0]),
    .line_q   (line_q),
    .mode_q   (mode_q),
    .baud_q   (baud_q)
  );

  logic              rx_ready, tx_empty, tx_done;
  logic [3:0]        err_q;
  logic [DATA_W-1:0] rx_buf, tx_buf;

  urb_flags #(.DATA_W(DATA_W)) u_flags (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .wr_txb       (wr_sel[IDX_TXB]),
    .rd_rxb       (rd_sel[IDX_RXB]),
    .rd_err       (rd_sel[IDX_ERR]),
    .wdata_byte   (bus_wdata[DATA_W-1:0]),
    .tx_taken     (tx_taken),
    .tx_shift_idle(tx_shift_idle),
    .rx_push      (rx_push),
    .rx_byte      (rx_byte),
    .rx_parity_err(rx_parity_err),
    .rx_frame_err (rx_frame_err),
    .rx_break     (rx_break),
    .rx_ready_q   (rx_ready),
    .tx_empty_q   (tx_empty),
    .tx_done_q    (tx_done),
    .err_q        (err_q),
    .rx_buf_q     (rx_buf),
    .tx_buf_q     (tx_buf)
  );

  urb_req u_req (
    .rx_mode (mode_q.rx_mode),
    .tx_mode (mode_q.tx_mode),
    .stat_ie (mode_q.stat_ie),
    .rx_ready(rx_ready),
    .tx_empty(tx_empty),
    .err_any (|err_q),
    .irq     (irq),
    .rx_dma  (rx_dma_req),
    .tx_dma  (tx_dma_req)
  );

  logic [31:0] rdata_d;
  logic        rd_en;
  logic [31:0] rdata_q;
  logic        rvalid_q;

  assign rd_en = bus_valid && !bus_write;

  always_comb begin
    rdata_d = '0;
    unique case (bus_index)
      IDX_LINE: rdata_d = 32'(line_q);
      IDX_MODE: rdata_d = 32'(mode_q);
      IDX_STAT: rdata_d = {29'b0, tx_done, tx_empty, rx_ready};
      IDX_ERR:  rdata_d = {28'b0, err_q};
      IDX_TXB:  rdata_d = 32'(tx_buf);
      IDX_RXB:  rdata_d = 32'(rx_buf);
      IDX_BAUD: rdata_d = 32'(baud_q);
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata     = rdata_q;
  assign bus_rvalid    = rvalid_q;
  assign line_word_len = line_q.word_len;
  assign line_two_stop = line_q.two_stop;
  assign line_parity   = line_q.parity;
  assign line_infrared = line_q.infrared;
  assign send_break    = mode_q.send_break;
  assign loopback      = mode_q.loopback;
  assign baud_div      = baud_q;
  assign tx_data       = tx_buf;
  assign tx_pending    = !tx_empty;

  AST_RVALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && !bus_write) |=> bus_rvalid); // R10
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && !bus_write && !slot_mapped(bus_index)) |=> (bus_rdata == 32'd0)); // R9
  AST_RX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && bus_write && bus_index == IDX_MODE && bus_wdata[1:0] == 2'b00) |=> (rx_dma_req == 2'b00)); // R6
  AST_TX_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_valid && bus_write && bus_index == IDX_MODE && bus_wdata[3:2] == 2'b00) |=> (tx_dma_req == 2'b00)); // R7
  AST_DMA_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(rx_dma_req) && $onehot0(tx_dma_req)); // R6
endmodule

// File: tb/uart_regbank_bench.sv
module uart_regbank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [3:0]  bus_index = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [1:0]  line_word_len;
  logic        line_two_stop;
  logic [2:0]  line_parity;
  logic        line_infrared, send_break, loopback;
  logic [31:0] baud_div;
  logic [7:0]  tx_data;
  logic        tx_pending;
  logic        tx_taken = 1'b0, tx_shift_idle = 1'b1;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        rx_parity_err = 1'b0, rx_frame_err = 1'b0, rx_break = 1'b0;
  logic        irq;
  logic [1:0]  rx_dma_req, tx_dma_req;

  int checks = 0;
  int failures = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  uart_regbank u_uart_regbank (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] data);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_index = idx; bus_wdata = data;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_valid = 1'b1; bus_write = 1'b0; bus_index = idx;
    @(negedge clk);
    bus_valid = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1'b1; rx_byte = b;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  // monitor: pops expected read data as results appear
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R10 unexpected read data actual=0x%08h expected=none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, bus_rdata, e);
      end
    end
  end

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 irq", 32'(irq), 0);
    check("R1 dma", {28'b0, rx_dma_req, tx_dma_req}, 0);
    rd(4'd0, 0, "R1 line");
    rd(4'd1, 0, "R1 mode");
    rd(4'd4, 32'h6, "R1 status");
    rd(4'd5, 0, "R1 err");
    rd(4'd10, 0, "R1 baud");

    // R2 config round trip
    wr(4'd0, 32'hFFFF_FF9D);
    rd(4'd0, 32'h1D, "R2 line readback");
    check("R2 line outs", {24'b0, line_infrared, line_parity, line_two_stop, line_word_len}, 32'h1D);
    wr(4'd1, 32'hFFFF_FFB0);
    rd(4'd1, 32'h30, "R2 mode readback");
    check("R2 break/loop", {30'b0, send_break, loopback}, 32'h3);
    wr(4'd10, 32'hDEAD_1234);
    rd(4'd10, 32'hDEAD_1234, "R2 baud readback");
    check("R2 baud out", baud_div, 32'hDEAD_1234);
    wr(4'd1, 0);

    // R9 unmapped and read-only slots
    wr(4'd3, 32'hFFFF_FFFF);
    rd(4'd3, 0, "R9 unmapped");
    wr(4'd4, 0);
    rd(4'd4, 32'h6, "R9 status ro");
    wr(4'd9, 32'hFF);
    rd(4'd9, 0, "R9 rxbuf ro");
    wr(4'd5, 32'hF);
    rd(4'd5, 0, "R9 err ro");
    rd(4'd1, 0, "R9 mode intact");

    // R3 / R6 receive via interrupt
    wr(4'd1, 32'h1);
    check("R6 rx irq idle", 32'(irq), 0);
    push(8'hA5);
    check("R6 rx irq", 32'(irq), 1);
    rd(4'd4, 32'h7, "R3 ready set");
    rd(4'd9, 32'hA5, "R3 rxbuf data");
    check("R3 irq drops", 32'(irq), 0);
    rd(4'd4, 32'h6, "R3 ready cleared");

    // R6 DMA routing
    wr(4'd1, 32'h2);
    push(8'h3C);
    check("R6 ch0", 32'(rx_dma_req), 1);
    check("R6 ch0 no irq", 32'(irq), 0);
    wr(4'd1, 32'h3);
    check("R6 ch1", 32'(rx_dma_req), 2);
    wr(4'd1, 32'h0);
    check("R6 off", 32'(rx_dma_req), 0);
    rd(4'd9, 32'h3C, "R3 rxbuf second");

    // R5 errors
    push(8'h11);
    push(8'h22);
    rd(4'd5, 32'h1, "R5 overrun");
    rd(4'd5, 32'h0, "R5 cleared");
    rd(4'd9, 32'h22, "R5 latest byte kept");
    @(negedge clk); rx_parity_err = 1'b1; @(negedge clk); rx_parity_err = 1'b0;
    rd(4'd5, 32'h2, "R5 parity");
    @(negedge clk); rx_frame_err = 1'b1; rx_break = 1'b1;
    @(negedge clk); rx_frame_err = 1'b0; rx_break = 1'b0;
    // R8 status interrupt
    check("R8 no ie", 32'(irq), 0);
    wr(4'd1, 32'h40);
    check("R8 irq on error", 32'(irq), 1);
    rd(4'd5, 32'hC, "R5 frame+break");
    check("R8 irq cleared", 32'(irq), 0);

    // R4 / R7 transmit
    wr(4'd1, 32'h4);
    check("R7 tx irq empty", 32'(irq), 1);
    tx_shift_idle = 1'b0;
    wr(4'd8, 32'h5A);
    check("R4 tx data", 32'(tx_data), 32'h5A);
    check("R4 pending", 32'(tx_pending), 1);
    check("R7 irq drops", 32'(irq), 0);
    rd(4'd4, 32'h0, "R4 empty+done cleared");
    @(negedge clk); tx_taken = 1'b1; @(negedge clk); tx_taken = 1'b0;
    rd(4'd4, 32'h2, "R4 empty after take");
    check("R7 irq back", 32'(irq), 1);
    tx_shift_idle = 1'b1;
    rd(4'd4, 32'h6, "R4 done after idle");
    wr(4'd1, 32'h8);
    check("R7 ch0", 32'(tx_dma_req), 1);
    wr(4'd1, 32'hC);
    check("R7 ch1", 32'(tx_dma_req), 2);
    check("R7 no irq", 32'(irq), 0);

    repeat (3) @(negedge clk);
    check("R10 all reads returned", 32'(exp_q.size()), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule